// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This block is a memory-mapped timer with two independent down-counting channels. Both channels advance on a shared tick input, a one-cycle enable that paces them, and their operating modes are set from one shared control word. Each channel holds a reload value and a live count, and both can be written and read over a simple 32-bit register port. Addresses are decoded from the full address, and reads return data combinationally in the same cycle.

A channel runs in one of two modes. In one-shot mode software writes a delta into the live count, and the channel expires once after that many ticks. It then rests at zero. In auto-reload mode the channel reloads its count from the reload register after passing through zero. This gives a periodic event whose period is the reload value plus one ticks. A reload value of all ones gives a counter that wraps through the whole counter range. Every expiry raises a one-cycle interrupt pulse on that channel's own output line. Channel 1's line is meant to serve as the system event timer.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, every register reads zero, both channels are stopped and both interrupt lines are low.
- R2: Register map by byte address: control at 0x00; channel c reload at 0x10+8c; channel c live count at 0x14+8c. In the control word, bit 2c is the run enable of channel c and bit 2c+1 is its auto-reload enable. Control bits above these, and written data bits above the counter width, are not stored and read as zero.
- R3: A running channel's count drops by exactly one on each clock edge where tick is high. The count is unchanged when tick is low or the channel's run bit is clear.
- R4: In one-shot mode, writing N (1 to 2^CNT_W-2) starts a countdown that expires on the Nth tick. The channel's interrupt line is high for exactly the one cycle right after that tick, and in that cycle the count reads zero.
- R5: After a one-shot expiry the count stays at zero and no further interrupt is raised until software writes the live count again.
- R6: In auto-reload mode, a tick that finds the count at zero loads the reload value. The channel therefore expires once every reload+1 ticks.
- R7: With reload and count both all ones and auto-reload on, the channel steps through every value. It reaches zero after 2^CNT_W-1 ticks and is back at all ones after 2^CNT_W ticks.
- R8: A bus write to a live count lands on the next edge and takes priority over a decrement in the same cycle. The tick in that cycle therefore cannot cause an expiry.
- R9: Reads of unmapped addresses, unaligned ones included, return zero. Writes to them change no register.
- R10: The channels are independent. Each interrupt output bit c reflects only channel c, and a stopped channel keeps its count while the other one runs.
- R11: Writing a reload register never changes the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Count enable, one decrement per high cycle |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, same cycle |
| expire_irq | output | NUM_CH | Per-channel expiry pulse, bit 1 is the event-timer line |

## Verification
The bench builds the timer with two channels and 8-bit counters while keeping the 32-bit data port. With this build, the full-range wrap of 256 ticks and the largest one-shot delta of 254 ticks can be reached within a short run, and dropping the upper data bits on a count write can be observed. Interrupt pulses are counted tick by tick, so the bench checks both the tick on which each expiry lands and that no extra pulse appears. The bench also drives writes and ticks in the same cycle to check that the write takes priority.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Address layout: control word first, then one 8-byte slot per channel.
  localparam int unsigned CTL_OFS    = 32'h00;
  localparam int unsigned CH_BASE    = 32'h10;
  localparam int unsigned CH_STRIDE  = 32'h08;
  localparam int unsigned VAL_DELTA  = 32'h04;

  // Two control bits per channel; run is the lower one.
  typedef struct packed {
    logic repeat_en;
    logic run;
  } chan_mode_t;

  function automatic int unsigned reload_ofs(input int unsigned ch);
    return CH_BASE + CH_STRIDE * ch;
  endfunction

  function automatic int unsigned value_ofs(input int unsigned ch);
    return CH_BASE + CH_STRIDE * ch + VAL_DELTA;
  endfunction

endpackage

// File: rtl/dct_rst_sync.sv
module dct_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dct_regbank.sv
module dct_regbank
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ADDR_W-1:0]                addr,
  input  logic                             wr_en,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic [NUM_CH-1:0][CNT_W-1:0]     count_i,
  output chan_mode_t [NUM_CH-1:0]          mode_o,
  output logic [NUM_CH-1:0][CNT_W-1:0]     reload_o,
  output logic [NUM_CH-1:0]                val_wr_o,
  output logic [CNT_W-1:0]                 val_wdata_o,
  output logic [DATA_W-1:0]                rd_data_o
);

  localparam int CTL_W = 2 * NUM_CH;

  // Address decode
  logic              hit_ctl;
  logic [NUM_CH-1:0] hit_rel;
  logic [NUM_CH-1:0] hit_val;

  always_comb begin
    hit_ctl = (32'(addr) == CTL_OFS);
    for (int c = 0; c < NUM_CH; c++) begin
      hit_rel[c] = (32'(addr) == reload_ofs(c));
      hit_val[c] = (32'(addr) == value_ofs(c));
    end
  end

  // Control word
  logic [CTL_W-1:0] ctl_q;
  logic [CTL_W-1:0] ctl_d;
  logic             ctl_le;

  always_comb begin
    ctl_le = wr_en & hit_ctl;
    ctl_d  = wr_data[CTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_le) begin
      ctl_q <= ctl_d;
    end
  end

  // Reload registers, one per channel
  logic [NUM_CH-1:0][CNT_W-1:0] rel_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_reload
    logic             rel_le;
    logic [CNT_W-1:0] rel_d;

    always_comb begin
      rel_le = wr_en & hit_rel[c];
      rel_d  = wr_data[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rel_q[c] <= '0;
      end else if (rel_le) begin
        rel_q[c] <= rel_d;
      end
    end

    assign mode_o[c] = chan_mode_t'(ctl_q[2*c +: 2]);
  end

  assign reload_o    = rel_q;
  assign val_wr_o    = {NUM_CH{wr_en}} & hit_val;
  assign val_wdata_o = wr_data[CNT_W-1:0];

  // Read return, zero for anything unmapped
  always_comb begin
    rd_data_o = '0;
    if (hit_ctl) begin
      rd_data_o[CTL_W-1:0] = ctl_q;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit_rel[c]) begin
        rd_data_o[CNT_W-1:0] = rel_q[c];
      end
      if (hit_val[c]) begin
        rd_data_o[CNT_W-1:0] = count_i[c];
      end
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wr_data;

endmodule

// File: rtl/dct_channel.sv
module dct_channel #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             repeat_en,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic             expire
);

  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_le;
  logic             exp_q;
  logic             exp_d;
  logic             step;

  // Next state: a bus load wins over a tick step.
  always_comb begin
    step   = tick & run;
    cnt_le = load | step;
    cnt_d  = cnt_q;
    exp_d  = 1'b0;
    if (load) begin
      cnt_d = load_val;
    end else if (step) begin
      if (cnt_q == CNT_ZERO) begin
        if (repeat_en) begin
          cnt_d = reload_val;
        end
      end else begin
        cnt_d = cnt_q - CNT_ONE;
        exp_d = (cnt_q == CNT_ONE);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_le) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q <= 1'b0;
    end else begin
      exp_q <= exp_d;
    end
  end

  assign count  = cnt_q;
  assign expire = exp_q;

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] expire_irq
);

  logic                         rst_n_sync;
  chan_mode_t [NUM_CH-1:0]      chan_mode;
  logic [NUM_CH-1:0][CNT_W-1:0] chan_reload;
  logic [NUM_CH-1:0][CNT_W-1:0] chan_count;
  logic [NUM_CH-1:0]            chan_load;
  logic [CNT_W-1:0]             chan_load_val;
  logic [NUM_CH-1:0]            chan_expire;

  dct_rst_sync #(
    .STAGES(2)
  ) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_sync)
  );

  dct_regbank #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_regbank (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .addr       (bus_addr),
    .wr_en      (bus_wr),
    .wr_data    (bus_wdata),
    .count_i    (chan_count),
    .mode_o     (chan_mode),
    .reload_o   (chan_reload),
    .val_wr_o   (chan_load),
    .val_wdata_o(chan_load_val),
    .rd_data_o  (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dct_channel #(
      .CNT_W(CNT_W)
    ) u_channel (
      .clk       (clk),
      .rst_n     (rst_n_sync),
      .tick      (tick),
      .run       (chan_mode[c].run),
      .repeat_en (chan_mode[c].repeat_en),
      .reload_val(chan_reload[c]),
      .load      (chan_load[c]),
      .load_val  (chan_load_val),
      .count     (chan_count[c]),
      .expire    (chan_expire[c])
    );
  end

  assign expire_irq = chan_expire;

endmodule

// File: rtl/dct_checker.sv
module dct_checker
  import dct_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         tick,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic                         bus_wr,
  input logic [DATA_W-1:0]            bus_wdata,
  input logic [DATA_W-1:0]            bus_rdata,
  input logic [NUM_CH-1:0]            expire_irq,
  input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
  input chan_mode_t [NUM_CH-1:0]      mode,
  input logic [NUM_CH-1:0][CNT_W-1:0] reload
);

  logic [NUM_CH-1:0] val_hit;
  logic              mapped;

  always_comb begin
    mapped = (32'(bus_addr) == CTL_OFS);
    for (int c = 0; c < NUM_CH; c++) begin
      val_hit[c] = bus_wr && (32'(bus_addr) == value_ofs(c));
      mapped = mapped || (32'(bus_addr) == reload_ofs(c))
                      || (32'(bus_addr) == value_ofs(c));
    end
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> bus_rdata == '0) else $error("unmapped read not zero"); // R9

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    AST_IRQ_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      expire_irq[c] |-> cnt[c] == '0) else $error("irq with nonzero count"); // R4

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      expire_irq[c] |=> !expire_irq[c]) else $error("irq wider than a cycle"); // R4

    AST_IRQ_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      expire_irq[c] |-> $past(tick)) else $error("irq without a tick"); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!(tick && mode[c].run) && !val_hit[c]) |=> $stable(cnt[c]))
      else $error("count moved without a tick"); // R3

    AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode[c].run && cnt[c] != '0 && !val_hit[c])
      |=> cnt[c] == CNT_W'($past(cnt[c]) - 1'b1))
      else $error("count did not step by one"); // R3

    AST_ONESHOT_REST: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode[c].repeat_en && cnt[c] == '0 && !val_hit[c])
      |=> (cnt[c] == '0 && !expire_irq[c]))
      else $error("one-shot left zero"); // R5

    AST_RELOAD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && mode[c].run && mode[c].repeat_en && cnt[c] == '0 && !val_hit[c])
      |=> cnt[c] == $past(reload[c]))
      else $error("auto-reload missed"); // R6

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      val_hit[c] |=> (cnt[c] == $past(bus_wdata[CNT_W-1:0]) && !expire_irq[c]))
      else $error("count write lost"); // R8
  end

endmodule

bind dual_countdown_timer dct_checker #(
  .NUM_CH(NUM_CH),
  .CNT_W (CNT_W),
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_dct_checker (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .tick      (tick),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .expire_irq(expire_irq),
  .cnt       (chan_count),
  .mode      (chan_mode),
  .reload    (chan_reload)
);

// File: tb/tb_dual_countdown_timer.sv
module tb_dual_countdown_timer;

  localparam int NUM_CH = 2;
  localparam int CNT_W  = 8;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NUM_CH-1:0] expire_irq;

  int checks = 0;
  int fails = 0;
  int n_irq[NUM_CH];
  int first_irq[NUM_CH];
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_countdown_timer #(
    .NUM_CH(NUM_CH),
    .CNT_W (CNT_W),
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .expire_irq(expire_irq)
  );

  // Table entry: write flag, address, data (expected value for reads), requirement.
  typedef struct packed {
    logic        wr;
    logic [4:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 5'h10, 32'h5A,  4'd2},   // R2 reload 0 write
    '{1'b0, 5'h10, 32'h5A,  4'd2},
    '{1'b0, 5'h14, 32'h00,  4'd11},  // R11 reload write leaves count
    '{1'b1, 5'h14, 32'h33,  4'd2},
    '{1'b0, 5'h14, 32'h33,  4'd2},
    '{1'b1, 5'h18, 32'hC3,  4'd2},
    '{1'b0, 5'h18, 32'hC3,  4'd2},
    '{1'b1, 5'h1C, 32'h81,  4'd2},
    '{1'b0, 5'h1C, 32'h81,  4'd2},
    '{1'b1, 5'h00, 32'hFF,  4'd2},   // control keeps only four bits
    '{1'b0, 5'h00, 32'h0F,  4'd2},
    '{1'b0, 5'h14, 32'h33,  4'd3},   // R3 running but tick low
    '{1'b1, 5'h00, 32'h00,  4'd2},
    '{1'b0, 5'h00, 32'h00,  4'd2},
    '{1'b1, 5'h04, 32'hAB,  4'd9},   // R9 unmapped write and read
    '{1'b0, 5'h04, 32'h00,  4'd9},
    '{1'b1, 5'h0C, 32'h12,  4'd9},
    '{1'b0, 5'h0C, 32'h00,  4'd9},
    '{1'b0, 5'h10, 32'h5A,  4'd9},
    '{1'b0, 5'h01, 32'h00,  4'd9},
    '{1'b1, 5'h14, 32'h1FF, 4'd2},   // upper data bits dropped
    '{1'b0, 5'h14, 32'hFF,  4'd2}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic bus_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // Write a count in the same cycle as a tick; returns the irq seen after that edge.
  task automatic write_with_tick(input logic [4:0] a, input logic [31:0] d,
                                 output logic [NUM_CH-1:0] irq_seen);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    tick      = 1'b1;
    @(posedge clk);
    #1;
    irq_seen = expire_irq;
    @(negedge clk);
    bus_wr = 1'b0;
    tick   = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    for (int c = 0; c < NUM_CH; c++) begin
      n_irq[c]     = 0;
      first_irq[c] = 0;
    end
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      tick = 1'b1;
      @(posedge clk);
      #1;
      for (int c = 0; c < NUM_CH; c++) begin
        if (expire_irq[c]) begin
          n_irq[c]++;
          if (first_irq[c] == 0) first_irq[c] = k;
        end
      end
    end
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [NUM_CH-1:0] irq_seen;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    bus_check(5'h00, 32'h0, "R1 control");
    bus_check(5'h10, 32'h0, "R1 reload0");
    bus_check(5'h14, 32'h0, "R1 count0");
    bus_check(5'h18, 32'h0, "R1 reload1");
    bus_check(5'h1C, 32'h0, "R1 count1");
    chk("R1 irq", 32'(expire_irq), 32'h0);

    // Register map walk (R2, R3, R9, R11)
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i].wr) begin
        bus_write(VEC[i].addr, VEC[i].data);
      end else begin
        bus_check(VEC[i].addr, VEC[i].data,
                  $sformatf("R%0d table[%0d]", VEC[i].req, i));
      end
    end

    // R3 stepping and halting
    bus_write(5'h14, 32'd10);
    bus_write(5'h00, 32'h1);
    bus_check(5'h14, 32'd10, "R3 no tick no step");
    run_ticks(3);
    bus_check(5'h14, 32'd7, "R3 three steps");
    bus_check(5'h1C, 32'h81, "R10 stopped channel holds");
    bus_write(5'h00, 32'h0);
    run_ticks(2);
    bus_check(5'h14, 32'd7, "R3 run bit clear");

    // R11 reload write while running
    bus_write(5'h00, 32'h1);
    bus_write(5'h10, 32'h77);
    bus_check(5'h14, 32'd7, "R11 count kept");
    bus_check(5'h10, 32'h77, "R11 reload stored");

    // R4 one-shot delta of five
    bus_write(5'h14, 32'd5);
    run_ticks(5);
    chk("R4 pulse count", 32'(n_irq[0]), 32'd1);
    chk("R4 expiry tick", 32'(first_irq[0]), 32'd5);
    chk("R10 other line quiet", 32'(n_irq[1]), 32'd0);
    bus_check(5'h14, 32'd0, "R4 count at zero");

    // R5 rest at zero, then rearm
    run_ticks(10);
    chk("R5 no further pulse", 32'(n_irq[0]), 32'd0);
    bus_check(5'h14, 32'd0, "R5 held zero");
    bus_write(5'h14, 32'd1);
    run_ticks(1);
    chk("R4 delta one pulses", 32'(n_irq[0]), 32'd1);
    chk("R4 delta one tick", 32'(first_irq[0]), 32'd1);

    // R4 largest delta
    bus_write(5'h14, 32'hFE);
    run_ticks(254);
    chk("R4 max delta pulses", 32'(n_irq[0]), 32'd1);
    chk("R4 max delta tick", 32'(first_irq[0]), 32'd254);

    // R6 periodic on channel 1, reload 3 -> period 4
    bus_write(5'h00, 32'h0);
    bus_write(5'h18, 32'd3);
    bus_write(5'h1C, 32'd3);
    bus_write(5'h00, 32'hC);
    run_ticks(12);
    chk("R6 pulses in twelve", 32'(n_irq[1]), 32'd3);
    chk("R6 first expiry", 32'(first_irq[1]), 32'd3);
    chk("R10 channel 0 quiet", 32'(n_irq[0]), 32'd0);
    bus_check(5'h1C, 32'd3, "R6 reloaded count");
    bus_check(5'h14, 32'd0, "R10 channel 0 unchanged");

    // R7 full-range wrap on channel 0
    bus_write(5'h00, 32'h0);
    bus_write(5'h10, 32'hFF);
    bus_write(5'h14, 32'hFF);
    bus_write(5'h00, 32'h3);
    run_ticks(256);
    chk("R7 one wrap pulse", 32'(n_irq[0]), 32'd1);
    chk("R7 zero reached", 32'(first_irq[0]), 32'd255);
    bus_check(5'h14, 32'hFF, "R7 back to all ones");
    bus_check(5'h1C, 32'd3, "R10 channel 1 stopped");

    // R8 write beats decrement
    bus_write(5'h00, 32'h1);
    bus_write(5'h14, 32'd9);
    write_with_tick(5'h14, 32'h40, irq_seen);
    bus_check(5'h14, 32'h40, "R8 write over tick");
    bus_write(5'h14, 32'd1);
    write_with_tick(5'h14, 32'h0, irq_seen);
    chk("R8 no expiry on write", 32'(irq_seen), 32'h0);
    bus_check(5'h14, 32'h0, "R8 written zero");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule